// File: doc/BRIEF.md
# Hardware Genetic Algorithm Engine

This block evolves a population of configuration bitstrings entirely in hardware. On a start pulse it fills its population with pseudo-random chromosomes drawn from an internal 32-bit LFSR loaded from a seed input. It then sends every individual, one at a time, to an external fitness evaluator, which can be a circuit under test in the loop. The evaluator returns an unsigned score, and higher scores are better.

Once a whole generation has been scored, the engine keeps the highest-scoring individuals unchanged as an elite. It refills every other slot with offspring of tournament-selected parents, using single-cut crossover and single-bit mutation at fixed rates. The engine stops when the best score reaches a target or when a generation limit runs out, and it then presents the best chromosome and its score.

The request side is a valid/ready stream. The engine raises `eval_valid` with a chromosome on `eval_chrom` and holds both steady for as long as `eval_ready` stays low, so the evaluator may stall it for any number of cycles. A transfer happens on a cycle where both signals are high. At most one request is outstanding at a time. The evaluator answers with a single-cycle `eval_done` pulse that carries `eval_fitness`, and it may take any number of cycles to do so.

Top module: `ga_engine`

## Requirements
- R1: After reset, `done` and `eval_valid` are low and `best_chrom` and `best_fitness` are zero.
- R2: A start loads the LFSR from `seed`, with a seed of zero replaced by a fixed nonzero constant. It then fills all POP slots with LFSR-derived random chromosomes. The same seed with the same evaluator timing repeats the same chromosome sequence.
- R3: While `eval_valid` is high and `eval_ready` is low, `eval_valid` and `eval_chrom` stay unchanged. After a transfer, `eval_valid` stays low until `eval_done` returns.
- R4: An `eval_done` pulse that arrives while no request is outstanding is ignored.
- R5: Each generation sends all POP individuals exactly once, in slot order from 0 to POP-1, and each is scored once.
- R6: Slots 0 to ELITE-1 (9 by default) of the next generation hold the ELITE highest-scoring individuals of the previous generation, unchanged. They appear in descending score order, and on equal scores the individual sent earlier comes first.
- R7: Each remaining slot holds an offspring of two parents, and each parent is the better of two uniformly drawn individuals. Crossover at one cut point happens when an 8-bit random value is below 179. Each child flips one random bit when its own 8-bit random value is below 10.
- R8: `target` and `max_gen` are captured at start, and a `max_gen` of 0 counts as 1. After each generation the engine stops if the best score is at or above the target, or if the number of generations evaluated has reached the limit. It then holds `done` high and sends no further requests.
- R9: At stop, `best_chrom` and `best_fitness` give the highest-scoring individual of the last evaluated generation, the earliest one on a tie. They hold until the next start.
- R10: `start` is acted on only while idle or done. A start after done drops `done` and runs a new search. A start during a run changes nothing, including the captured target and limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (idle or done only) |
| seed | input | 32 | LFSR seed captured at start |
| target | input | FW | Stop score, captured at start |
| max_gen | input | GW | Generation limit, captured at start |
| eval_valid | output | 1 | Chromosome request valid |
| eval_ready | input | 1 | Evaluator accepts request |
| eval_chrom | output | W | Chromosome to be scored |
| eval_done | input | 1 | Single-cycle score return |
| eval_fitness | input | FW | Score, higher is better |
| done | output | 1 | Search finished |
| best_chrom | output | W | Best chromosome of last generation |
| best_fitness | output | FW | Its score |

## Verification
Two stop conditions can become true at the end of the same generation: reaching the fitness target and running out of generations. The bench provokes this with a target of zero and a limit of one. It judges the result by counting exactly POP requests, then seeing `done` stay high with no further requests. It also checks that the reported best equals the earliest top score it handed out. A second overlap is a spurious `eval_done` that lands while a request is stalled by back-pressure. This is provoked with an impossible score during stalls and judged by that score never showing up as the best.

// File: rtl/ga_pkg.sv
package ga_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_EVAL, S_WAIT, S_DECIDE,
    S_TA, S_TB, S_X, S_M, S_COPY, S_DONE
  } ga_state_t;
endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr #(
  parameter int          STEPS    = 32,
  parameter logic [31:0] ZERO_ALT = 32'h1ACE_B00C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  output logic [31:0] state
);
  logic [31:0] nx;

  // Galois form, several steps per clock so each cycle sees fresh bits
  always_comb begin
    nx = state;
    for (int i = 0; i < STEPS; i++)
      nx = nx[0] ? ((nx >> 1) ^ 32'h8020_0003) : (nx >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= ZERO_ALT;
    else if (load) state <= (seed == 32'd0) ? ZERO_ALT : seed;
    else           state <= nx;
  end
endmodule

// File: rtl/ga_elite.sv
module ga_elite #(
  parameter int W     = 16,
  parameter int FW    = 16,
  parameter int ELITE = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       ins,
  input  logic [FW-1:0]              in_fit,
  input  logic [W-1:0]               in_chr,
  output logic [ELITE-1:0][FW-1:0]   el_fit,
  output logic [ELITE-1:0][W-1:0]    el_chr,
  output logic [ELITE-1:0]           el_vld
);
  logic [ELITE-1:0]          keep, v_n;
  logic [ELITE-1:0][FW-1:0]  f_n;
  logic [ELITE-1:0][W-1:0]   c_n;

  // sorted insertion: a slot keeps its entry when that entry is at least as good
  for (genvar k = 0; k < ELITE; k++) begin : g_slot
    assign keep[k] = el_vld[k] && (el_fit[k] >= in_fit);
    if (k == 0) begin : g_head
      assign f_n[k] = keep[k] ? el_fit[k] : in_fit;
      assign c_n[k] = keep[k] ? el_chr[k] : in_chr;
      assign v_n[k] = 1'b1;
    end else begin : g_tail
      assign f_n[k] = keep[k] ? el_fit[k] : (keep[k-1] ? in_fit : el_fit[k-1]);
      assign c_n[k] = keep[k] ? el_chr[k] : (keep[k-1] ? in_chr : el_chr[k-1]);
      assign v_n[k] = el_vld[k] | el_vld[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_vld <= '0;
      el_fit <= '0;
      el_chr <= '0;
    end else if (clear) begin
      el_vld <= '0;
    end else if (ins) begin
      el_vld <= v_n;
      el_fit <= f_n;
      el_chr <= c_n;
    end
  end
endmodule

// File: rtl/ga_mate.sv
module ga_mate #(
  parameter int W      = 16,
  parameter int XO_TH  = 179,
  parameter int MUT_TH = 10
) (
  input  logic [W-1:0]  pa,
  input  logic [W-1:0]  pb,
  input  logic [31:0]   xr,
  input  logic [31:0]   mr,
  output logic [W-1:0]  ca,
  output logic [W-1:0]  cb
);
  localparam int PW = $clog2(W);
  localparam int QW = 9 + PW;

  logic          do_x, mut_a, mut_b;
  logic [QW-1:0] cut_p, pos_a_p, pos_b_p;
  logic [PW:0]   cut, pos_a, pos_b;
  logic [W-1:0]  mask, flip_a, flip_b;

  assign do_x    = xr[7:0] < 8'(XO_TH);
  assign cut_p   = {{(PW+1){1'b0}}, xr[15:8]} * QW'(W-1);
  assign cut     = cut_p[QW-1:8] + 1'b1;
  assign mut_a   = mr[7:0]   < 8'(MUT_TH);
  assign mut_b   = mr[23:16] < 8'(MUT_TH);
  assign pos_a_p = {{(PW+1){1'b0}}, mr[15:8]}  * QW'(W);
  assign pos_b_p = {{(PW+1){1'b0}}, mr[31:24]} * QW'(W);
  assign pos_a   = pos_a_p[QW-1:8];
  assign pos_b   = pos_b_p[QW-1:8];

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign mask[b]   = (PW+1)'(b) < cut;
    assign flip_a[b] = mut_a && (pos_a == (PW+1)'(b));
    assign flip_b[b] = mut_b && (pos_b == (PW+1)'(b));
  end

  assign ca = (do_x ? ((pa & mask) | (pb & ~mask)) : pa) ^ flip_a;
  assign cb = (do_x ? ((pb & mask) | (pa & ~mask)) : pb) ^ flip_b;
endmodule

// File: rtl/ga_engine.sv
module ga_engine
  import ga_pkg::*;
#(
  parameter int W      = 16,
  parameter int POP    = 100,
  parameter int ELITE  = 9,
  parameter int FW     = 16,
  parameter int GW     = 16,
  parameter int XO_TH  = 179,
  parameter int MUT_TH = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   seed,
  input  logic [FW-1:0] target,
  input  logic [GW-1:0] max_gen,
  output logic          eval_valid,
  input  logic          eval_ready,
  output logic [W-1:0]  eval_chrom,
  input  logic          eval_done,
  input  logic [FW-1:0] eval_fitness,
  output logic          done,
  output logic [W-1:0]  best_chrom,
  output logic [FW-1:0] best_fitness
);
  localparam int IW = $clog2(POP);
  localparam int CW = IW + 1;
  localparam int PRW = 16 + IW;

  ga_state_t state;
  logic [W-1:0]  pop [POP];
  logic [W-1:0]  nxt [POP];
  logic [W-1:0]  refill [POP];
  logic [FW-1:0] fit [POP];
  logic [IW-1:0] idx, ia, ib;
  logic [CW-1:0] wr_idx, wr1;
  logic [GW-1:0] gen_q, lim_q, gen_next;
  logic [FW-1:0] tgt_q;
  logic [W-1:0]  par_a, par_b, winner, kid_a, kid_b;
  logic [31:0]   rnd, xo_q;
  logic          start_ok, el_clear, el_ins;
  logic [ELITE-1:0][FW-1:0] el_fit;
  logic [ELITE-1:0][W-1:0]  el_chr;
  logic [ELITE-1:0]         el_vld;

  function automatic logic [IW-1:0] pick(input logic [15:0] r);
    logic [PRW-1:0] p;
    p = {{IW{1'b0}}, r} * PRW'(POP);
    return p[PRW-1:16];
  endfunction

  assign start_ok   = start && (state == S_IDLE || state == S_DONE);
  assign el_clear   = (state == S_INIT && idx == IW'(POP-1)) || state == S_COPY;
  assign el_ins     = (state == S_WAIT) && eval_done;
  assign ia         = pick(rnd[15:0]);
  assign ib         = pick(rnd[31:16]);
  assign winner     = (fit[ib] > fit[ia]) ? pop[ib] : pop[ia];
  assign gen_next   = gen_q + 1'b1;
  assign wr1        = wr_idx + 1'b1;
  assign eval_valid = (state == S_EVAL);
  assign eval_chrom = pop[idx];
  assign done       = (state == S_DONE);

  ga_lfsr u_rng (.clk(clk), .rst_n(rst_n), .load(start_ok), .seed(seed), .state(rnd));

  ga_elite #(.W(W), .FW(FW), .ELITE(ELITE)) u_elite (
    .clk(clk), .rst_n(rst_n), .clear(el_clear), .ins(el_ins),
    .in_fit(eval_fitness), .in_chr(pop[idx]),
    .el_fit(el_fit), .el_chr(el_chr), .el_vld(el_vld));

  ga_mate #(.W(W), .XO_TH(XO_TH), .MUT_TH(MUT_TH)) u_mate (
    .pa(par_a), .pb(par_b), .xr(xo_q), .mr(rnd), .ca(kid_a), .cb(kid_b));

  for (genvar k = 0; k < POP; k++) begin : g_refill
    if (k < ELITE) begin : g_keep
      assign refill[k] = el_chr[k];
    end else begin : g_child
      assign refill[k] = nxt[k];
    end
  end

  // population, score and offspring storage
  always_ff @(posedge clk) begin
    if (state == S_INIT) pop[idx] <= rnd[W-1:0];
    if (state == S_COPY)
      for (int k = 0; k < POP; k++) pop[k] <= refill[k];
    if (el_ins) fit[idx] <= eval_fitness;
    if (state == S_M) begin
      nxt[wr_idx[IW-1:0]] <= kid_a;
      if (wr1 < CW'(POP)) nxt[wr1[IW-1:0]] <= kid_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      idx          <= '0;
      wr_idx       <= '0;
      gen_q        <= '0;
      lim_q        <= '0;
      tgt_q        <= '0;
      par_a        <= '0;
      par_b        <= '0;
      xo_q         <= '0;
      best_chrom   <= '0;
      best_fitness <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start_ok) begin
          state <= S_INIT;
          idx   <= '0;
          gen_q <= '0;
          tgt_q <= target;
          lim_q <= (max_gen == '0) ? GW'(1) : max_gen;
        end
        S_INIT: begin
          if (idx == IW'(POP-1)) begin
            state <= S_EVAL;
            idx   <= '0;
          end else idx <= idx + 1'b1;
        end
        S_EVAL: if (eval_ready) state <= S_WAIT;
        S_WAIT: if (eval_done) begin
          if (idx == IW'(POP-1)) state <= S_DECIDE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_EVAL;
          end
        end
        S_DECIDE: begin
          gen_q        <= gen_next;
          best_chrom   <= el_chr[0];
          best_fitness <= el_fit[0];
          if (el_fit[0] >= tgt_q || gen_next >= lim_q) state <= S_DONE;
          else begin
            wr_idx <= CW'(ELITE);
            state  <= S_TA;
          end
        end
        S_TA: begin
          par_a <= winner;
          state <= S_TB;
        end
        S_TB: begin
          par_b <= winner;
          state <= S_X;
        end
        S_X: begin
          xo_q  <= rnd;
          state <= S_M;
        end
        S_M: begin
          wr_idx <= wr_idx + CW'(2);
          state  <= (wr_idx + CW'(2) >= CW'(POP)) ? S_COPY : S_TA;
        end
        S_COPY: begin
          idx   <= '0;
          state <= S_EVAL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ga_engine_chk.sv
module ga_engine_chk #(
  parameter int W     = 16,
  parameter int FW    = 16,
  parameter int GW    = 16,
  parameter int ELITE = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     eval_valid,
  input logic                     eval_ready,
  input logic [W-1:0]             eval_chrom,
  input logic                     done,
  input logic [FW-1:0]            best_fitness,
  input logic [W-1:0]             best_chrom,
  input logic [31:0]              rnd,
  input logic [FW-1:0]            tgt_q,
  input logic [GW-1:0]            gen_q,
  input logic [GW-1:0]            lim_q,
  input logic [ELITE-1:0][FW-1:0] el_fit,
  input logic [ELITE-1:0]         el_vld
);
  AST_CHROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid && !eval_ready |=> eval_valid && $stable(eval_chrom)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    eval_valid && eval_ready |=> !eval_valid); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !eval_valid); // R8
  AST_STOP_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && (best_fitness < tgt_q) |-> gen_q >= lim_q); // R8
  AST_RNG_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != 32'd0); // R2
  AST_ELITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    el_vld[1] |-> el_fit[0] >= el_fit[1]); // R6
  AST_BEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(best_fitness) && $stable(best_chrom)); // R9
endmodule

bind ga_engine ga_engine_chk #(.W(W), .FW(FW), .GW(GW), .ELITE(ELITE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .eval_valid(eval_valid),
  .eval_ready(eval_ready), .eval_chrom(eval_chrom), .done(done),
  .best_fitness(best_fitness), .best_chrom(best_chrom), .rnd(rnd),
  .tgt_q(tgt_q), .gen_q(gen_q), .lim_q(lim_q), .el_fit(el_fit), .el_vld(el_vld));

// File: tb/tb_ga_engine.sv
`timescale 1ns/1ps
module tb_ga_engine;
  localparam int POP = 100;
  localparam int ELITE = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] seed = '0;
  logic [15:0] target = '0;
  logic [15:0] max_gen = '0;
  logic        eval_valid, eval_ready = 1'b1;
  logic [15:0] eval_chrom;
  logic        eval_done = 1'b0;
  logic [15:0] eval_fitness = '0;
  logic        done;
  logic [15:0] best_chrom, best_fitness;

  ga_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .target(target),
    .max_gen(max_gen), .eval_valid(eval_valid), .eval_ready(eval_ready),
    .eval_chrom(eval_chrom), .eval_done(eval_done), .eval_fitness(eval_fitness),
    .done(done), .best_chrom(best_chrom), .best_fitness(best_fitness));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [15:0] log_c [0:1023];
  logic [15:0] ref_c [0:POP-1];
  int n_sent = 0;
  int resp_delay = 0;
  bit ready_mode = 0, spurious_en = 0;
  int stall_err = 0, out_err = 0, n_stall = 0, cyc = 0;

  function automatic logic [15:0] fitf(input logic [15:0] c);
    return {1'b0, c[15:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ready pattern, changed shortly after the rising edge
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    eval_ready = ready_mode ? ((cyc % 5) >= 2) : 1'b1;
  end

  // evaluator model
  initial forever begin
    @(negedge clk);
    eval_done = 1'b0;
    if (eval_valid && eval_ready) begin
      logic [15:0] c;
      c = eval_chrom;
      if (n_sent < 1024) log_c[n_sent] = c;
      n_sent++;
      @(posedge clk);
      for (int d = 0; d < resp_delay; d++) begin
        @(negedge clk);
        if (eval_valid) out_err++;
      end
      @(negedge clk);
      if (eval_valid) out_err++;
      eval_done = 1'b1;
      eval_fitness = fitf(c);
    end else if (spurious_en && eval_valid && !eval_ready) begin
      eval_done = 1'b1;
      eval_fitness = 16'hFFFF;
    end
  end

  // back-pressure monitor
  initial begin
    bit pend = 0;
    logic [15:0] pchr = '0;
    forever begin
      @(negedge clk);
      if (pend && !(eval_valid && eval_chrom == pchr)) stall_err++;
      pend = eval_valid && !eval_ready;
      pchr = eval_chrom;
      if (pend) n_stall++;
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk(done, req, "done reached", done, 1);
  endtask

  task automatic run(input logic [31:0] s, input logic [15:0] t, input logic [15:0] mg,
                     input string req);
    @(negedge clk);
    seed = s; target = t; max_gen = mg; n_sent = 0;
    pulse_start();
    wait_done(req);
  endtask

  function automatic int best_idx(input int base);
    int j = base;
    for (int k = base + 1; k < base + POP; k++)
      if (fitf(log_c[k]) > fitf(log_c[j])) j = k;
    return j;
  endfunction

  function automatic int distinct(input int base);
    int n = 0;
    for (int k = base; k < base + POP; k++) begin
      bit seen = 0;
      for (int m = base; m < k; m++) if (log_c[m] == log_c[k]) seen = 1;
      if (!seen) n++;
    end
    return n;
  endfunction

  task automatic check_elite(input int g);
    bit taken [POP];
    int base = g * POP;
    for (int k = 0; k < POP; k++) taken[k] = 0;
    for (int k = 0; k < ELITE; k++) begin
      int j = -1;
      for (int m = 0; m < POP; m++)
        if (!taken[m] && (j < 0 || fitf(log_c[base+m]) > fitf(log_c[base+j]))) j = m;
      taken[j] = 1;
      chk(log_c[base+POP+k] == log_c[base+j], "R6", "elite slot",
          log_c[base+POP+k], log_c[base+j]);
    end
  endtask

  task automatic t_reset();
    chk(!done, "R1", "done after reset", done, 0);
    chk(!eval_valid, "R1", "eval_valid after reset", eval_valid, 0);
    chk(best_chrom == 0 && best_fitness == 0, "R1", "best after reset",
        best_fitness, 0);
  endtask

  task automatic t_first_gen_target();
    int j;
    run(32'h1234_5678, 16'd0, 16'd20, "R8");
    chk(n_sent == POP, "R5", "requests in one generation", n_sent, POP);
    j = best_idx(0);
    chk(best_fitness == fitf(log_c[j]), "R9", "best fitness", best_fitness, fitf(log_c[j]));
    chk(best_chrom == log_c[j], "R9", "best chrom earliest max", best_chrom, log_c[j]);
    chk(distinct(0) >= 60, "R2", "random initial population", distinct(0), 60);
    for (int k = 0; k < POP; k++) ref_c[k] = log_c[k];
  endtask

  task automatic t_gen_limit();
    int j, novel, copies;
    longint s0, s1;
    run(32'hCAFE_F00D, 16'hFFFF, 16'd3, "R8");
    chk(n_sent == 3 * POP, "R8", "generation limit requests", n_sent, 3 * POP);
    check_elite(0);
    check_elite(1);
    j = best_idx(2 * POP);
    chk(best_chrom == log_c[j] && best_fitness == fitf(log_c[j]), "R9",
        "best of last generation", best_fitness, fitf(log_c[j]));
    novel = 0; copies = 0;
    for (int k = POP + ELITE; k < 2 * POP; k++) begin
      bit hit = 0;
      for (int m = 0; m < POP; m++) if (log_c[m] == log_c[k]) hit = 1;
      if (hit) copies++; else novel++;
    end
    chk(novel > 0, "R7", "offspring with variation", novel, 1);
    chk(copies > 0, "R7", "offspring copied unchanged", copies, 1);
    s0 = 0; s1 = 0;
    for (int k = 0; k < POP; k++) begin
      s0 += fitf(log_c[k]);
      s1 += fitf(log_c[POP + k]);
    end
    chk(s1 > s0, "R7", "tournament raises mean score", s1, s0);
  endtask

  task automatic t_determinism();
    int same;
    run(32'h1234_5678, 16'd0, 16'd1, "R2");
    same = 0;
    for (int k = 0; k < POP; k++) if (log_c[k] == ref_c[k]) same++;
    chk(same == POP, "R2", "same seed repeats sequence", same, POP);
    run(32'h0, 16'd0, 16'd1, "R2");
    chk(distinct(0) >= 60, "R2", "zero seed still random", distinct(0), 60);
  endtask

  task automatic t_backpressure();
    int j;
    ready_mode = 1; resp_delay = 3; spurious_en = 1;
    stall_err = 0; out_err = 0; n_stall = 0;
    run(32'h0BAD_5EED, 16'hFFFF, 16'd2, "R3");
    ready_mode = 0; resp_delay = 0; spurious_en = 0;
    chk(n_stall > 0, "R3", "stalls occurred", n_stall, 1);
    chk(stall_err == 0, "R3", "request held under stall", stall_err, 0);
    chk(out_err == 0, "R3", "single outstanding request", out_err, 0);
    chk(n_sent == 2 * POP, "R4", "request count with stray done", n_sent, 2 * POP);
    chk(best_fitness != 16'hFFFF, "R4", "stray done ignored", best_fitness, 0);
    j = best_idx(POP);
    chk(best_fitness == fitf(log_c[j]), "R4", "best from real scores",
        best_fitness, fitf(log_c[j]));
  endtask

  task automatic t_both_stop_and_restart();
    int extra = 0;
    bit held = 1;
    run(32'h5555_AAAA, 16'd0, 16'd1, "R8");
    chk(n_sent == POP, "R8", "both stop conditions at once", n_sent, POP);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (eval_valid) extra++;
      if (!done) held = 0;
    end
    chk(extra == 0, "R8", "no requests after done", extra, 0);
    chk(held, "R9", "done held", held, 1);
    chk(n_sent == POP, "R8", "count unchanged after done", n_sent, POP);
    pulse_start();
    chk(!done, "R10", "restart clears done", done, 0);
    wait_done("R10");
  endtask

  task automatic t_busy_start();
    @(negedge clk);
    seed = 32'h7777_1111; target = 16'hFFFF; max_gen = 16'd2; n_sent = 0;
    pulse_start();
    repeat (50) @(negedge clk);
    target = 16'd0; max_gen = 16'd1; seed = 32'h1;
    pulse_start();
    wait_done("R10");
    chk(n_sent == 2 * POP, "R10", "start while busy ignored", n_sent, 2 * POP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_gen_target();
    t_gen_limit();
    t_determinism();
    t_backpressure();
    t_both_stop_and_restart();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule